// File: doc/BRIEF.md
# Channel-Banked Configuration Register File

This block holds the configuration registers of a four-channel device behind a simple byte access port. A two-wire management slave front end drives the port with an address, write data, a write strobe and a read strobe, and collects the read data one cycle later. The register space has two kinds of page. The shared page holds device-wide control and status. Each channel has its own page, and all channel pages sit at the same low addresses. One page-steering register sits at the top address, 0xFF. It is never banked, and it decides which page the other addresses reach.

When bit 2 of the steering register is low, low addresses reach the shared page. When bit 2 is high, they reach the channel whose index is in bits 1:0. Bit 3 turns channel writes into a write to all channels at once. Reads still come from the selected channel while bit 3 is set. At the first clock after reset the block samples the address strap inputs once, and it only keeps them when the mode pins allow it. The captured value can be read back from shared address 0x00. A one-shot flag records that an external configuration load finished. A reload request bit in shared control register 0x04 rearms that flag. All register contents also drive flat output vectors that feed the channel logic.

Top module: `chbank_regfile`

## Requirements
- R1: After synchronous reset every shared and channel register, the steering register 0xFF, the load-done flag, `reload_req` and `rd_data` are all 0x00.
- R2: Address 0xFF always reaches the steering register, whatever page is selected. All 8 bits can be written and read back. It changes only when address 0xFF is written.
- R3: While steering bit 2 is 0, addresses below 0x08 reach the shared page. Writes in this state leave every channel register unchanged.
- R4: While steering bit 2 is 1, addresses below 0x10 reach the page of the channel given by steering bits 1:0. A write there changes only that channel's register.
- R5: While steering bits 2 and 3 are both 1, a channel-page write updates the same address in all four channels. A read returns the register of the channel in bits 1:0.
- R6: Strap capture happens once, on the first clock edge after reset is released. The strap value is loaded if `master_mode` is 1 or `rd_en_mode` is 0. Otherwise the latched value keeps its default of 0. Later changes on the strap pins have no effect.
- R7: Shared address 0x00 reads the latched strap in bits 3:0, with the upper bits 0. Writes to it are ignored.
- R8: Bit 5 of shared register 0x04 drives `reload_req`. It stays set until software writes it back to 0.
- R9: Shared address 0x01 is read-only. Its bit 0 is set by a `load_done` pulse and cleared by a write to 0x04 with bit 5 set. When both happen in the same cycle, the set wins.
- R10: `rd_data` shows the addressed register on the cycle after `rd_en`, using the state from before any write in that same cycle. It holds its value while no read is issued.
- R11: Unimplemented addresses read 0x00 and ignore writes. These are 0x08 to 0xFE on the shared page and 0x10 to 0xFE on a channel page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, one cycle after `rd_en` |
| strap_in | input | 4 | Address strap pins |
| master_mode | input | 1 | 1 when the device loads its own configuration |
| rd_en_mode | input | 1 | Read-enable mode pin; must be low for a slave to latch its straps |
| load_done | input | 1 | One-cycle pulse at the end of an external configuration load |
| reload_req | output | 1 | Reload request, shared 0x04 bit 5 |
| chan_sel | output | 8 | Steering register contents |
| shared_regs | output | 64 | Shared page, byte i at bits 8i+7:8i |
| chan_regs | output | 512 | Channel pages, channel c register r at byte c*16+r |

## Verification
Strap capture is the hardest behaviour to reach, because it happens only in the single cycle after reset. To cover it, the stimulus resets the block several times, each time under a different combination of mode pins and strap values. After each capture it changes the strap pins and checks that shared 0x00 has not moved. A broadcast write followed by a read of a non-broadcast channel is also only reachable through a sequence of steering writes. So the random stimulus flips the page and broadcast bits often, and the flat channel outputs are compared against a model after every operation.

// File: rtl/chbank_regfile.sv
module chbank_regfile #(
  parameter int NUM_CH  = 4,
  parameter int CH_REGS = 16,
  parameter int SH_REGS = 8,
  parameter int STRAP_W = 4,
  parameter logic [STRAP_W-1:0] STRAP_DEF = '0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [7:0]                  addr,
  input  logic [7:0]                  wdata,
  input  logic                        wr_en,
  input  logic                        rd_en,
  output logic [7:0]                  rd_data,
  input  logic [STRAP_W-1:0]          strap_in,
  input  logic                        master_mode,
  input  logic                        rd_en_mode,
  input  logic                        load_done,
  output logic                        reload_req,
  output logic [7:0]                  chan_sel,
  output logic [SH_REGS*8-1:0]        shared_regs,
  output logic [NUM_CH*CH_REGS*8-1:0] chan_regs
);
  localparam int SA_W = $clog2(SH_REGS);
  localparam int CA_W = $clog2(CH_REGS);
  localparam int CTRL_IDX = 4;
  localparam int RELOAD_BIT = 5;

  logic [7:0]         sel_q;
  logic [STRAP_W-1:0] strap_q;
  logic               cap_done;
  logic               flag_q;
  logic [7:0]         sh_q [2:SH_REGS-1];
  logic [7:0]         ch_q [NUM_CH][CH_REGS];
  logic [7:0]         sh_view [SH_REGS];
  logic [7:0]         rd_mux;

  wire       page   = sel_q[2];
  wire       bcast  = sel_q[3];
  wire [1:0] cidx   = sel_q[1:0];
  wire       hit_sel = (addr == 8'hFF);
  wire       hit_sh  = !hit_sel && !page && (addr < 8'(SH_REGS));
  wire       hit_ch  = !hit_sel && page && (addr < 8'(CH_REGS));
  wire       wr_ctrl = wr_en && hit_sh && (addr[SA_W-1:0] == SA_W'(CTRL_IDX));

  assign chan_sel   = sel_q;
  assign reload_req = sh_q[CTRL_IDX][RELOAD_BIT];
  assign sh_view[0] = {{(8-STRAP_W){1'b0}}, strap_q};
  assign sh_view[1] = {7'b0, flag_q};

  genvar gi, gc, gr;
  generate
    for (gi = 2; gi < SH_REGS; gi++) begin : g_shv
      assign sh_view[gi] = sh_q[gi];
    end
    for (gi = 0; gi < SH_REGS; gi++) begin : g_shf
      assign shared_regs[gi*8 +: 8] = sh_view[gi];
    end
    for (gc = 0; gc < NUM_CH; gc++) begin : g_chc
      for (gr = 0; gr < CH_REGS; gr++) begin : g_chr
        assign chan_regs[(gc*CH_REGS+gr)*8 +: 8] = ch_q[gc][gr];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q  <= STRAP_DEF;
      cap_done <= 1'b0;
    end else if (!cap_done) begin
      cap_done <= 1'b1;
      if (master_mode || !rd_en_mode) strap_q <= strap_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      flag_q <= 1'b0;
      for (int i = 2; i < SH_REGS; i++) sh_q[i] <= '0;
      for (int c = 0; c < NUM_CH; c++)
        for (int r = 0; r < CH_REGS; r++) ch_q[c][r] <= '0;
    end else begin
      if (load_done) flag_q <= 1'b1;
      else if (wr_ctrl && wdata[RELOAD_BIT]) flag_q <= 1'b0;
      if (wr_en && hit_sel) sel_q <= wdata;
      for (int i = 2; i < SH_REGS; i++)
        if (wr_en && hit_sh && addr[SA_W-1:0] == SA_W'(i)) sh_q[i] <= wdata;
      for (int c = 0; c < NUM_CH; c++)
        for (int r = 0; r < CH_REGS; r++)
          if (wr_en && hit_ch && addr[CA_W-1:0] == CA_W'(r) && (bcast || cidx == 2'(c)))
            ch_q[c][r] <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_sel) rd_mux = sel_q;
    else if (hit_sh) rd_mux = sh_view[addr[SA_W-1:0]];
    else if (hit_ch) rd_mux = ch_q[cidx][addr[CA_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

module chbank_regfile_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic [7:0] chan_sel,
  input logic       reload_req,
  input logic       load_done,
  input logic       flag,
  input logic [3:0] strap_view,
  input logic       cap_done
);
  p_sel_only_by_write_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == 8'hFF) |=> $stable(chan_sel));
  p_strap_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    cap_done |=> $stable(strap_view));
  p_reload_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == 8'h04) |=> $stable(reload_req));
  p_flag_set_r9: assert property (@(posedge clk) disable iff (rst)
    load_done |=> flag);
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind chbank_regfile chbank_regfile_chk u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .chan_sel(chan_sel), .reload_req(reload_req),
  .load_done(load_done), .flag(shared_regs[8]), .strap_view(shared_regs[3:0]),
  .cap_done(cap_done)
);

// File: tb/chbank_regfile_bench.sv
module chbank_regfile_bench;
  logic clk = 0, rst = 1;
  logic [7:0] addr = 0, wdata = 0;
  logic wr_en = 0, rd_en = 0, master_mode = 0, rd_en_mode = 1, load_done = 0;
  logic [3:0] strap_in = 0;
  logic [7:0] rd_data, chan_sel;
  logic reload_req;
  logic [63:0] shared_regs;
  logic [511:0] chan_regs;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  logic [7:0] m_sel, m_sh [8], m_ch [4][16], m_last;
  logic [3:0] m_strap;
  logic m_flag;

  always #4 clk = ~clk;

  chbank_regfile u_chbank_regfile (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
    .rd_data(rd_data), .strap_in(strap_in), .master_mode(master_mode),
    .rd_en_mode(rd_en_mode), .load_done(load_done), .reload_req(reload_req),
    .chan_sel(chan_sel), .shared_regs(shared_regs), .chan_regs(chan_regs));

  task automatic check(string req, logic [511:0] act, logic [511:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [7:0] a);
    if (a == 8'hFF) return m_sel;
    if (!m_sel[2]) begin
      if (a == 0) return {4'b0, m_strap};
      if (a == 1) return {7'b0, m_flag};
      if (a < 8) return m_sh[a[2:0]];
      return 8'h00;
    end
    if (a < 16) return m_ch[m_sel[1:0]][a[3:0]];
    return 8'h00;
  endfunction

  function automatic void model_write(logic [7:0] a, logic [7:0] d);
    if (a == 8'hFF) m_sel = d;
    else if (!m_sel[2]) begin
      if (a >= 2 && a < 8) m_sh[a[2:0]] = d;
      if (a == 4 && d[5]) m_flag = 0;
    end else if (a < 16) begin
      for (int c = 0; c < 4; c++)
        if (m_sel[3] || m_sel[1:0] == 2'(c)) m_ch[c][a[3:0]] = d;
    end
  endfunction

  function automatic logic [511:0] exp_ch();
    logic [511:0] v;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 16; r++) v[(c*16+r)*8 +: 8] = m_ch[c][r];
    return v;
  endfunction

  function automatic logic [63:0] exp_sh();
    logic [63:0] v;
    v[7:0] = {4'b0, m_strap};
    v[15:8] = {7'b0, m_flag};
    for (int i = 2; i < 8; i++) v[i*8 +: 8] = m_sh[i];
    return v;
  endfunction

  task automatic model_reset();
    m_sel = 0; m_flag = 0; m_last = 0;
    for (int i = 0; i < 8; i++) m_sh[i] = 0;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 16; r++) m_ch[c][r] = 0;
  endtask

  task automatic do_reset(logic mm, logic rem, logic [3:0] st);
    @(negedge clk);
    rst = 1; master_mode = mm; rd_en_mode = rem; strap_in = st;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    model_reset();
    m_strap = (mm || !rem) ? st : 4'h0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, string req);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    model_write(a, d);
    check(req, {448'b0, shared_regs}, {448'b0, exp_sh()});
    check(req, chan_regs, exp_ch());
    check(req, {504'b0, rd_data}, {504'b0, m_last});
  endtask

  task automatic rd(logic [7:0] a, string req);
    logic [7:0] e;
    e = exp_read(a);
    @(negedge clk);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    m_last = e;
    check(req, {504'b0, rd_data}, {504'b0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R6: slave mode with read-enable high keeps default
    do_reset(0, 1, 4'hA);
    check("R6 default strap", {508'b0, shared_regs[3:0]}, 512'h0);
    // R1 reset state
    check("R1 chan regs", chan_regs, 512'b0);
    check("R1 sel", {504'b0, chan_sel}, 512'b0);
    check("R1 rd_data", {504'b0, rd_data}, 512'b0);
    check("R1 reload", {511'b0, reload_req}, 512'b0);
    // R6: slave mode with read-enable low latches, then pins ignored
    do_reset(0, 0, 4'h5);
    strap_in = 4'hC;
    repeat (3) @(negedge clk);
    check("R6 latched once", {508'b0, shared_regs[3:0]}, 512'h5);
    rd(8'h00, "R7 strap readback");
    wr(8'h00, 8'hFF, "R7 write ignored");
    rd(8'h00, "R7 strap after write");
    // R6: master mode latches regardless
    do_reset(1, 1, 4'h9);
    check("R6 master latch", {508'b0, shared_regs[3:0]}, 512'h9);
    // R9 / R8 flag and reload
    @(negedge clk); load_done = 1; @(negedge clk); load_done = 0;
    m_flag = 1;
    rd(8'h01, "R9 flag set");
    wr(8'h01, 8'h00, "R9 read-only");
    wr(8'h04, 8'h20, "R8 reload set clears flag R9");
    check("R8 reload_req", {511'b0, reload_req}, 512'b1);
    repeat (4) @(negedge clk);
    check("R8 reload held", {511'b0, reload_req}, 512'b1);
    wr(8'h04, 8'h00, "R8 reload clear");
    check("R8 reload_req low", {511'b0, reload_req}, 512'b0);
    @(negedge clk); addr = 8'h04; wdata = 8'h20; wr_en = 1; load_done = 1;
    @(negedge clk); wr_en = 0; load_done = 0;
    model_write(8'h04, 8'h20); m_flag = 1;
    rd(8'h01, "R9 set wins");
    // R3/R4/R5/R11 directed
    wr(8'h05, 8'h3C, "R3 shared write");
    wr(8'hFF, 8'h06, "R2 select ch2 page");
    wr(8'h05, 8'hA5, "R4 channel write");
    rd(8'h05, "R4 channel read");
    wr(8'hFF, 8'h0D, "R5 broadcast sel ch1");
    wr(8'h0F, 8'h77, "R5 broadcast write");
    rd(8'h0F, "R5 read selected");
    wr(8'h10, 8'h99, "R11 channel unimpl write");
    rd(8'h10, "R11 channel unimpl read");
    rd(8'hFF, "R2 sel readback");
    wr(8'hFF, 8'h00, "R2 back to shared");
    wr(8'h08, 8'h99, "R11 shared unimpl write");
    rd(8'h08, "R11 shared unimpl read");
    rd(8'h05, "R3 shared read");
    // random mix
    for (int n = 0; n < 1500; n++) begin
      int k;
      logic [7:0] a;
      k = $urandom_range(0, 9);
      a = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'($urandom_range(0, 18));
      if (k == 0) wr(8'hFF, {4'($urandom), 4'($urandom)}, "R2 random sel");
      else if (k < 5) wr(a, 8'($urandom), "R3 R4 R5 random write");
      else if (k < 9) rd(a, "R10 random read");
      else rd(8'hFF, "R2 random sel read");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule